// File: doc/BRIEF.md
# Rewindable Word Queue with Half-Level Flag

This block is a first-in first-out store of 256 words of 9 bits each. Words leave in exactly the order they arrived. All control inputs are active low and are sampled on one system clock. One write strobe and one read strobe drive the queue. A master reset clears it. A rewind input moves the read position back to the first location, so that a message already read can be sent out again without writing it a second time.

The block reports three levels: empty, full and more-than-half-full. The half-level indication is suppressed when the block is strapped for cascaded use. The read data bus models a tristate driver: it carries a word only while the read strobe is low, and it has a separate enable output. At all other times it is held at zero.

A typical use is a retry buffer. A producer loads a packet of up to 256 words after reset and a consumer drains it. If the far end reports an error, the consumer pulses the rewind input and drains the same packet again.

Top module: `retx_fifo`

## Requirements
- R1: Words of 9 bits are returned in the order they were written, and up to 256 words can be held.
- R2: Each clock edge with `wrN` low and the queue not full stores `dataIn`. Each edge with `rdN` low and the queue not empty removes the oldest word. While `rdN` is low, `dataOut` shows the oldest word before that edge.
- R3: `dataOe` is high exactly when `rdN` is low. Whenever `dataOe` is low, `dataOut` is all zeros.
- R4: A write while full and a read while empty are ignored. No stored word is overwritten and the read position does not move.
- R5: `emptyFlag` is high exactly when 0 words are held. `fullFlag` is high exactly when 256 words are held. The two are never high together.
- R6: With `expandMode` low, `halfFlag` is high when 129 or more words are held and low at 128 or fewer. With `expandMode` high, `halfFlag` is always low.
- R7: An edge with `rtN` low and both `wrN` and `rdN` high sets the read position to the first location. The stored count becomes the number of words written since reset, so the data is read out again from the first word.
- R8: `rtN` low while either strobe is low has no rewind effect, and the strobes act as in R2.
- R9: An edge with `rstN` low clears both positions and the count. After it, empty is high and full and half are low.
- R10: When neither full nor empty, a simultaneous read and write keeps the count unchanged. When full, a simultaneous read and write performs only the read. When empty, it performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Master reset, active low, synchronous |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| rtN | input | 1 | Rewind request, active low |
| expandMode | input | 1 | High when cascaded; disables the half flag |
| dataIn | input | 9 | Word to store |
| dataOut | output | 9 | Oldest word while reading, zero otherwise |
| dataOe | output | 1 | Models the output driver enable |
| emptyFlag | output | 1 | No words held |
| fullFlag | output | 1 | 256 words held |
| halfFlag | output | 1 | More than 128 words held (standalone only) |

## Verification
The main function is driven with four kinds of traffic:
- Lone writes and lone reads, which show ordering and the level flags.
- Reads and writes in the same cycle, at partial fill, at full and at empty. These separate the three arbitration outcomes of R10.
- A complete fill to 256 words followed by a rewind and a full drain. This shows that no word was overwritten while full, and that the half threshold falls at 129/128 in both directions.
- A rewind request with a strobe low. Reading out the next word shows whether the read position moved.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rewind;
  } fifoStrobes_t;
endpackage

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrN,
  input  logic                       rdN,
  input  logic                       rtN,
  input  logic                       expandMode,
  output fifoStrobes_t               strobes,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       emptyFlag,
  output logic                       fullFlag,
  output logic                       halfFlag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2 + 1);

  logic [CW-1:0] wrTotal;   // words written since reset (wraps past 2*DEPTH)
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] count;

  logic isEmpty, isFull;
  assign isEmpty = (count == '0);
  assign isFull  = (count == FULL_CNT);

  always_comb begin
    strobes.rewind = !rtN && wrN && rdN;
    strobes.wrEn   = !wrN && !isFull;
    strobes.rdEn   = !rdN && !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrTotal <= '0;
      rdPtr   <= '0;
      count   <= '0;
    end else if (strobes.rewind) begin
      rdPtr <= '0;
      count <= wrTotal;
    end else begin
      if (strobes.wrEn) wrTotal <= wrTotal + 1'b1;
      if (strobes.rdEn) rdPtr   <= rdPtr + 1'b1;
      case ({strobes.wrEn, strobes.rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign wrAddr    = wrTotal[AW-1:0];
  assign rdAddr    = rdPtr;
  assign emptyFlag = isEmpty;
  assign fullFlag  = isFull;
  assign halfFlag  = !expandMode && (count >= HALF_MARK);
endmodule

// File: rtl/retx_fifo_dpath.sv
module retx_fifo_dpath
  import retx_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  fifoStrobes_t               strobes,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic                       rdN,
  input  logic [WIDTH-1:0]           dataIn,
  output logic [WIDTH-1:0]           dataOut,
  output logic                       dataOe
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] headWord;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= dataIn;
  end

  assign headWord = store[rdAddr];
  assign dataOe   = !rdN;

  for (genvar b = 0; b < WIDTH; b++) begin : g_drv
    assign dataOut[b] = dataOe & headWord[b];
  end
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             rtN,
  input  logic             expandMode,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe,
  output logic             emptyFlag,
  output logic             fullFlag,
  output logic             halfFlag
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobes_t strobes;
  logic [AW-1:0] wrAddr, rdAddr;

  retx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .expandMode(expandMode), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .halfFlag(halfFlag)
  );

  retx_fifo_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdN(rdN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/retx_fifo_check.sv
module retx_fifo_check #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrN,
  input logic             rdN,
  input logic             rtN,
  input logic             expandMode,
  input logic [WIDTH-1:0] dataOut,
  input logic             dataOe,
  input logic             emptyFlag,
  input logic             fullFlag,
  input logic             halfFlag
);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !wrN && rdN) |=> fullFlag);

  a_r4_no_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && !rdN && wrN && rtN) |=> emptyFlag);

  a_r3_zero_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

  a_r3_enable_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOe == !rdN);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(emptyFlag && fullFlag));

  a_r6_half_gated: assert property (@(posedge clk) disable iff (!rstN)
    halfFlag |-> (!expandMode && !emptyFlag));

  a_r10_count_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyFlag && !fullFlag && !wrN && !rdN) |=> $stable({emptyFlag, fullFlag}));

  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> (emptyFlag && !fullFlag && !halfFlag));
endmodule

bind retx_fifo retx_fifo_check #(.WIDTH(WIDTH)) u_check (.*);

// File: tb/retx_fifo_test.sv
module retx_fifo_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 256;

  logic clk = 0;
  logic rstN = 0, wrN = 1, rdN = 1, rtN = 1, expandMode = 0;
  logic [8:0] dataIn = '0;
  logic [8:0] dataOut;
  logic dataOe, emptyFlag, fullFlag, halfFlag;
  int nChecks = 0, nFail = 0;

  retx_fifo uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // vector: wrN rdN rtN din[9] chkData expData[9] expEmpty expFull
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,9'h101,1'b0,9'h000,1'b0,1'b0},  // R2 write
    {1'b0,1'b1,1'b1,9'h0A5,1'b0,9'h000,1'b0,1'b0},
    {1'b0,1'b1,1'b1,9'h1FF,1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h101,1'b0,1'b0},  // R1 oldest first
    {1'b0,1'b0,1'b1,9'h033,1'b1,9'h0A5,1'b0,1'b0},  // R10 both
    {1'b1,1'b1,1'b0,9'h000,1'b0,9'h000,1'b0,1'b0},  // R7 rewind
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h101,1'b0,1'b0},
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h0A5,1'b0,1'b0},
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h1FF,1'b0,1'b0},
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h033,1'b1,1'b0},
    {1'b1,1'b0,1'b1,9'h000,1'b0,9'h000,1'b1,1'b0},  // R4 read empty
    {1'b0,1'b1,1'b0,9'h077,1'b0,9'h000,1'b0,1'b0},  // R8 rt with write
    {1'b1,1'b0,1'b1,9'h000,1'b1,9'h077,1'b1,1'b0}   // R8 no rewind
  };

  function automatic logic [8:0] wv(input int i);
    return 9'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic t, input logic [8:0] d,
                     input logic chkD, input logic [8:0] expD, input string tag);
    @(negedge clk);
    wrN = w; rdN = r; rtN = t; dataIn = d;
    #1;
    if (chkD) chk(tag, dataOut, expD);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wrN = 1; rdN = 1; rtN = 1;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    wrN = 1; rdN = 1; rtN = 1; rstN = 0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired, all requirements");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R9 reset state, R3 bus off
    chk("R9 empty after reset", emptyFlag, 1);
    chk("R9 full after reset", fullFlag, 0);
    chk("R9 half after reset", halfFlag, 0);
    chk("R3 oe off", dataOe, 0);
    chk("R3 bus zero", dataOut, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20:12], VEC[v][11], VEC[v][10:2],
          $sformatf("R1/R2/R7/R8 data vec%0d", v));
      chk($sformatf("R5 empty vec%0d", v), emptyFlag, VEC[v][1]);
      chk($sformatf("R5 full vec%0d", v), fullFlag, VEC[v][0]);
    end
    idle();
    chk("R3 oe off after reads", dataOe, 0);

    // R6 expansion mode suppresses half flag
    doReset();
    expandMode = 1;
    for (int i = 0; i < 200; i++) cyc(0, 1, 1, wv(i), 0, 0, "R6");
    chk("R6 half suppressed", halfFlag, 0);
    @(negedge clk);
    expandMode = 0;
    #1;
    chk("R6 half standalone at 200", halfFlag, 1);

    // full fill, overflow, rewind, drain
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 1, 1, wv(i), 0, 0, "R2");
      if (i == 127) chk("R6 half at 128", halfFlag, 0);
      if (i == 128) chk("R6 half at 129", halfFlag, 1);
      if (i == 254) chk("R5 not full at 255", fullFlag, 0);
    end
    chk("R5 full at 256", fullFlag, 1);
    cyc(0, 1, 1, 9'h1AA, 0, 0, "R4");
    chk("R4 still full after blocked write", fullFlag, 1);
    cyc(1, 1, 0, 0, 0, 0, "R7");
    chk("R7 full after rewind", fullFlag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 0, 1, 0, 1, wv(i), $sformatf("R1/R4/R7 word %0d", i));
      if (i == 126) chk("R6 half falling at 129", halfFlag, 1);
      if (i == 127) chk("R6 half falling at 128", halfFlag, 0);
    end
    chk("R5 empty after drain", emptyFlag, 1);
    cyc(1, 0, 1, 0, 0, 0, "R4");
    chk("R4 empty after blocked read", emptyFlag, 1);

    // R10 at full: read wins, write blocked
    doReset();
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 1, wv(i), 0, 0, "R10");
    cyc(0, 0, 1, 9'h1CC, 1, wv(0), "R10 head at full");
    chk("R10 not full after read+write at full", fullFlag, 0);
    cyc(1, 1, 0, 0, 0, 0, "R10");
    chk("R10 write blocked, rewind count 256", fullFlag, 1);

    // R10 at empty: write wins, read blocked
    doReset();
    cyc(0, 0, 1, 9'h0EE, 0, 0, "R10");
    chk("R10 not empty after read+write at empty", emptyFlag, 0);
    cyc(1, 0, 1, 0, 1, 9'h0EE, "R10 stored word");
    chk("R10 empty after read", emptyFlag, 1);

    // R9 reset from a partly filled state
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, wv(i), 0, 0, "R9");
    doReset();
    #1;
    chk("R9 empty after mid reset", emptyFlag, 1);
    chk("R9 full after mid reset", fullFlag, 0);
    cyc(0, 1, 1, 9'h011, 0, 0, "R9");
    cyc(1, 0, 1, 0, 1, 9'h011, "R9 first word after reset");
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule